// File: doc/BRIEF.md
# Platform Control and Identification Register Block

This block is a byte-wide register file in a small system's I/O port space. It decodes a 16-bit port address and uses separate read and write strobes. It holds the platform's control state: a soft-reset request, a little-endian mode flag, a disk-activity lamp, a 4-bit system control field and an I/O map-type select. It also answers identification reads with fixed constants that describe the board's processor and its fitted features.

Some ports act differently on write than on read. A write to either of two lock ports produces a one-cycle request pulse to an external NVRAM lock. A read of the first of those ports returns a fixed feature code. The identification ports ignore writes. Every address that is not decoded reads as 0xFF, and a write to one changes nothing. The NVRAM, the caches and the processor reset sequence sit outside this block. The block only produces the request outputs for them.

Read data is combinational from the address while the read strobe is high. A write takes effect on the rising clock edge at which the write strobe is high.

Top module: `plat_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset clears the soft-reset request, the endian flag, the lamp, the control field, the map select and both lock pulses to 0.
- R2: A write to port 0x0092 loads the soft-reset request from data bit 0 and the little-endian flag from data bit 1.
- R3: A read of port 0x0092 returns the little-endian flag in bit 1 and 0 in all other bits.
- R4: Ports 0x0800, 0x0802 and 0x0803 read 0xEF, 0xAD and 0xE0. Writes to them leave every output unchanged.
- R5: Port 0x080C reads 0x3C, port 0x0818 reads 0x00 and port 0x0823 reads 0x03.
- R6: A write to port 0x0808 loads the lamp output from data bit 0.
- R7: A write to port 0x0810 raises the lock-1 pulse, and a write to port 0x0812 raises the lock-2 pulse. Each pulse is high for exactly the one cycle after the write edge, and the two are never high together. A read of port 0x0810 returns 0x39.
- R8: A write to port 0x081C stores data bits 3:0 in the control field, and a read of that port returns the field zero-extended. The field changes only on such a write.
- R9: A write to port 0x0850 stores data bit 0 as the map select (0 selects the contiguous map), and a read returns it in bit 0.
- R10: A read of any other port returns 0xFF. This includes 0x0808, 0x0812, 0x0814 and addresses that differ from a decoded port only in upper bits. A write to such a port changes no output.
- R11: While the read strobe is low, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| soft_rst_req | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| lamp_on | output | 1 | Disk-activity lamp |
| lock1_toggle | output | 1 | One-cycle NVRAM lock-1 toggle request |
| lock2_toggle | output | 1 | One-cycle NVRAM lock-2 toggle request |
| sys_ctl | output | 4 | System control field |
| map_sel | output | 1 | I/O map-type select |

## Verification
The bench targets the asymmetric ports, which are the easiest to get wrong.

| Corner case | What a faulty design would show |
|---|---|
| A read of lock port 0x0810 | A design that shared read and write decoding would return 0xFF here instead of 0x39. |
| Back-to-back writes to the two lock ports | A pulse that is stretched, or that lands on the wrong output, appears as a mismatch in the cycle after each edge. |
| Writes of 0xFF to the identification ports and to 0x0814 | A sloppy decoder would show these as changes on the control outputs. |
| Addresses such as 0x1092 and 0x0093 | A partial decode would alias them onto real registers instead of reading 0xFF. |
| Writes of 0xF5 to the control port | Storing more than four bits, or truncating to fewer, appears on the read back. |

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int CTRL_W    = 4;
    localparam int NUM_LOCKS = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Port map
    localparam addr_t P_RSTEND = 16'h0092;
    localparam addr_t P_CPUID  = 16'h0800;
    localparam addr_t P_FEAT   = 16'h0802;
    localparam addr_t P_STAT   = 16'h0803;
    localparam addr_t P_LAMP   = 16'h0808;
    localparam addr_t P_EQUIP  = 16'h080C;
    localparam addr_t P_LOCKA  = 16'h0810;
    localparam addr_t P_LOCKB  = 16'h0812;
    localparam addr_t P_KEY    = 16'h0818;
    localparam addr_t P_SYSCTL = 16'h081C;
    localparam addr_t P_CACHE  = 16'h0823;
    localparam addr_t P_MAP    = 16'h0850;

    // Fixed read values
    localparam byte_t K_CPUID = 8'hEF;
    localparam byte_t K_FEAT  = 8'hAD;
    localparam byte_t K_STAT  = 8'hE0;
    localparam byte_t K_EQUIP = 8'h3C;
    localparam byte_t K_XFEAT = 8'h39;
    localparam byte_t K_KEY   = 8'h00;
    localparam byte_t K_CACHE = 8'h03;
    localparam byte_t K_FLOAT = 8'hFF;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_RSTEND, SEL_CPUID, SEL_FEAT, SEL_STAT, SEL_LAMP,
        SEL_EQUIP, SEL_LOCKA, SEL_LOCKB, SEL_KEY, SEL_SYSCTL, SEL_CACHE,
        SEL_MAP
    } sel_e;

    typedef struct packed {
        logic              soft_rst;
        logic              le;
        logic              lamp;
        logic [CTRL_W-1:0] ctl;
        logic              map;
    } state_t;

    function automatic sel_e decode_port(addr_t a);
        case (a)
            P_RSTEND: return SEL_RSTEND;
            P_CPUID:  return SEL_CPUID;
            P_FEAT:   return SEL_FEAT;
            P_STAT:   return SEL_STAT;
            P_LAMP:   return SEL_LAMP;
            P_EQUIP:  return SEL_EQUIP;
            P_LOCKA:  return SEL_LOCKA;
            P_LOCKB:  return SEL_LOCKB;
            P_KEY:    return SEL_KEY;
            P_SYSCTL: return SEL_SYSCTL;
            P_CACHE:  return SEL_CACHE;
            P_MAP:    return SEL_MAP;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic sel_e lock_sel(int idx);
        return (idx == 0) ? SEL_LOCKA : SEL_LOCKB;
    endfunction
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
    import pcr_pkg::*;
(
    input  addr_t addr,
    output sel_e  sel
);
    always_comb sel = decode_port(addr);
endmodule

// File: rtl/pcr_state.sv
module pcr_state
    import pcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  sel_e              sel,
    input  logic [CTRL_W-1:0] wbits,
    output state_t            st,
    output logic [NUM_LOCKS-1:0] lock_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_RSTEND: begin
                    st.soft_rst <= wbits[0];
                    st.le       <= wbits[1];
                end
                SEL_LAMP:   st.lamp <= wbits[0];
                SEL_SYSCTL: st.ctl  <= wbits;
                SEL_MAP:    st.map  <= wbits[0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) lock_q[i] <= 1'b0;
            else     lock_q[i] <= wr_en && (sel == lock_sel(i));
        end
    end

    // R7
    lock_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_LOCKA) |=> (lock_q == 2'b01));
    // R7
    lock_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lock_q));
    // R8
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_SYSCTL) |=> $stable(st.ctl));
    // R2
    le_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_RSTEND) |=> (st.le == $past(wbits[1])));
    // R4
    id_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_CPUID || sel == SEL_FEAT || sel == SEL_STAT))
        |=> ($stable(st) && lock_q == '0));
endmodule

// File: rtl/pcr_rdmux.sv
module pcr_rdmux
    import pcr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_en,
    input  sel_e   sel,
    input  state_t st,
    output byte_t  rdata
);
    byte_t val;

    always_comb begin
        case (sel)
            SEL_RSTEND: val = byte_t'({st.le, 1'b0});
            SEL_CPUID:  val = K_CPUID;
            SEL_FEAT:   val = K_FEAT;
            SEL_STAT:   val = K_STAT;
            SEL_EQUIP:  val = K_EQUIP;
            SEL_LOCKA:  val = K_XFEAT;
            SEL_KEY:    val = K_KEY;
            SEL_SYSCTL: val = byte_t'(st.ctl);
            SEL_CACHE:  val = K_CACHE;
            SEL_MAP:    val = byte_t'(st.map);
            default:    val = K_FLOAT;
        endcase
        rdata = rd_en ? val : '0;
    end

    // R3
    endian_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_RSTEND) |-> (rdata[7:2] == '0 && rdata[0] == 1'b0));
endmodule

// File: rtl/plat_ctrl_regs.sv
module plat_ctrl_regs
    import pcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        soft_rst_req,
    output logic        le_mode,
    output logic        lamp_on,
    output logic        lock1_toggle,
    output logic        lock2_toggle,
    output logic [3:0]  sys_ctl,
    output logic        map_sel
);
    sel_e                 sel;
    state_t               st;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CTRL_W];

    pcr_decode u_dec (.addr(addr), .sel(sel));

    pcr_state u_st (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel),
        .wbits(wdata[CTRL_W-1:0]), .st(st), .lock_q(lock_q)
    );

    pcr_rdmux u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .st(st), .rdata(rdata)
    );

    assign soft_rst_req = st.soft_rst;
    assign le_mode      = st.le;
    assign lamp_on      = st.lamp;
    assign sys_ctl      = st.ctl;
    assign map_sel      = st.map;
    assign lock1_toggle = lock_q[0];
    assign lock2_toggle = lock_q[1];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st == '0 && lock_q == '0));
endmodule

// File: tb/sim_plat_ctrl_regs.sv
`timescale 1ns/1ps
module sim_plat_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        soft_rst_req, le_mode, lamp_on, lock1_toggle, lock2_toggle, map_sel;
    logic [3:0]  sys_ctl;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // reference model state
    int m_soft = 0, m_le = 0, m_lamp = 0, m_ctl = 0, m_map = 0, m_l1 = 0, m_l2 = 0;

    always #4 clk = ~clk;

    plat_ctrl_regs u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .soft_rst_req(soft_rst_req),
        .le_mode(le_mode), .lamp_on(lamp_on), .lock1_toggle(lock1_toggle),
        .lock2_toggle(lock2_toggle), .sys_ctl(sys_ctl), .map_sel(map_sel)
    );

    task automatic cmp(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_read(int a);
        case (a)
            'h0092: return m_le * 2;
            'h0800: return 'hEF;
            'h0802: return 'hAD;
            'h0803: return 'hE0;
            'h080C: return 'h3C;
            'h0810: return 'h39;
            'h0818: return 'h00;
            'h081C: return m_ctl;
            'h0823: return 'h03;
            'h0850: return m_map;
            default: return 'hFF;
        endcase
    endfunction

    function automatic string read_req(int a);
        case (a)
            'h0092: return "R3 endian read";
            'h0800, 'h0802, 'h0803: return "R4 id read";
            'h080C, 'h0818, 'h0823: return "R5 const read";
            'h0810: return "R7 lock port read";
            'h081C: return "R8 ctl read";
            'h0850: return "R9 map read";
            default: return "R10 float read";
        endcase
    endfunction

    task automatic check_outputs(string tag);
        cmp({tag, " R2 soft_rst_req"}, soft_rst_req, m_soft);
        cmp({tag, " R2 le_mode"}, le_mode, m_le);
        cmp({tag, " R6 lamp_on"}, lamp_on, m_lamp);
        cmp({tag, " R7 lock1_toggle"}, lock1_toggle, m_l1);
        cmp({tag, " R7 lock2_toggle"}, lock2_toggle, m_l2);
        cmp({tag, " R8 sys_ctl"}, sys_ctl, m_ctl);
        cmp({tag, " R9 map_sel"}, map_sel, m_map);
    endtask

    // One bus cycle: drive, check combinational read, clock, update model, check outputs.
    task automatic cyc(int a, bit w, bit r, int d);
        @(negedge clk);
        addr = 16'(a); wr_en = w; rd_en = r; wdata = 8'(d);
        #1;
        if (r) cmp(read_req(a), rdata, ref_read(a));
        else   cmp("R11 idle rdata", rdata, 0);
        @(posedge clk);
        #1;
        m_l1 = (w && a == 'h0810) ? 1 : 0;
        m_l2 = (w && a == 'h0812) ? 1 : 0;
        if (w) begin
            case (a)
                'h0092: begin m_soft = d & 1; m_le = (d >> 1) & 1; end
                'h0808: m_lamp = d & 1;
                'h081C: m_ctl = d & 'hF;
                'h0850: m_map = d & 1;
                default: ;
            endcase
        end
        check_outputs("cycle");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int pool[16] = '{'h0092, 'h0800, 'h0802, 'h0803, 'h0808, 'h080C, 'h0810,
                         'h0812, 'h0814, 'h0818, 'h081C, 'h0823, 'h0850, 'h1092,
                         'h0093, 'h0851};
        // reset with write traffic that must not land (R1)
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            addr = 16'h0092; wr_en = 1'b1; wdata = 8'hFF;
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        check_outputs("R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3
        cyc('h0092, 1, 0, 'h03);
        cyc('h0092, 0, 1, 0);
        cyc('h0092, 1, 0, 'h02);
        cyc('h0092, 0, 1, 0);
        cyc('h0092, 1, 0, 'hFC);
        cyc('h0092, 0, 1, 0);
        // R4 writes ignored
        cyc('h0800, 1, 0, 'hFF);
        cyc('h0802, 1, 0, 'hFF);
        cyc('h0803, 1, 0, 'hFF);
        cyc('h0800, 0, 1, 0);
        cyc('h0802, 0, 1, 0);
        cyc('h0803, 0, 1, 0);
        // R5
        cyc('h080C, 0, 1, 0);
        cyc('h0818, 0, 1, 0);
        cyc('h0823, 0, 1, 0);
        // R6
        cyc('h0808, 1, 0, 'hFF);
        cyc('h0808, 0, 1, 0);
        cyc('h0808, 1, 0, 'hFE);
        // R7 back-to-back lock writes
        cyc('h0810, 1, 0, 0);
        cyc('h0812, 1, 0, 0);
        cyc('h0810, 1, 0, 0);
        cyc('h0810, 0, 1, 0);
        cyc('h0812, 0, 1, 0);
        // R8
        cyc('h081C, 1, 0, 'hF5);
        cyc('h081C, 0, 1, 0);
        cyc('h081C, 1, 0, 'h0A);
        cyc('h081C, 0, 1, 0);
        // R9
        cyc('h0850, 1, 0, 'hFF);
        cyc('h0850, 0, 1, 0);
        cyc('h0850, 1, 0, 'hFE);
        cyc('h0850, 0, 1, 0);
        // R10 undecoded
        cyc('h0814, 1, 0, 'hFF);
        cyc('h0814, 0, 1, 0);
        cyc('h1092, 1, 0, 'hFF);
        cyc('h1092, 0, 1, 0);
        cyc('h0093, 0, 1, 0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int a = pool[$urandom_range(15, 0)];
            bit w = 1'($urandom_range(1, 0));
            bit r = 1'($urandom_range(1, 0));
            cyc(a, w, r, int'($urandom_range(255, 0)));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule